// File: doc/BRIEF.md
# Output Voltage Window Monitor

This block watches a digitized output-sense sample, expressed in millivolts, and decides whether a step-down converter's output is healthy. It raises a power-good flag when soft-start has finished and the sample sits inside a hysteretic window around the reference. It also latches two protective faults. An undervoltage fault turns both power switches off. An overvoltage fault turns the high-side switch off and drives a crowbar on the low-side switch.

The crowbar stays armed for as long as the overvoltage fault is latched. Whenever a sample climbs above the overvoltage limit, the low-side switch is forced on again. It is released once a sample falls below half of the reference. A disconnected sense line reads as full scale and therefore trips the overvoltage path. The synchronous reset models a supply power cycle and is the only way to clear a latched fault. The converter keeps switching while power-good is low for window reasons alone.

Top module: `vwin_monitor`

## Requirements
- R1: Reset clears both fault flags and all three switch commands, and drives power_good low.
- R2: power_good goes high one cycle after the state below holds, and stays low while any fault is latched.
  - The condition: soft-start has been seen at least once since reset, and the most recent valid sample placed the output inside the window.
- R3: The window drops on a sample above 890 or below 710.
  - After a drop on the high side, the window is regained only by a sample at or below 870.
  - After a drop on the low side, it is regained only by a sample at or above 730.
- R4: Once soft-start has been seen, a valid sample below 600 latches uv_fault, hs_force_off and ls_force_off. They stay latched, whatever later samples show, until reset.
- R5: Before soft-start has been seen, samples below 600 latch no undervoltage fault.
- R6: A valid sample above 1000 latches ov_fault and hs_force_off and sets ls_force_on, whether or not soft-start has been seen. ov_fault stays latched until reset.
- R7: While ov_fault is latched, ls_force_on is cleared by a valid sample below 400. Samples from 400 up to 1000 leave ls_force_on unchanged.
- R8: After a release, any later valid sample above 1000 sets ls_force_on again.
- R9: The full-scale code (all ones), which is what an unconnected sense line reads, is handled as an overvoltage.
- R10: Cycles with sample_valid low change no fault flag, switch command or window decision, whatever sense_mv carries.
- R11: When both faults are latched, overvoltage handling wins. ls_force_off stays low and ls_force_on follows the crowbar. ls_force_on and ls_force_off are never high together.
- R12: All comparisons are strict. The exact codes 1000, 600, 890 and 710 do not trip their limits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (supply power cycle) |
| sample_valid | input | 1 | Qualifies sense_mv for this cycle |
| sense_mv | input | SENSE_W | Sense sample in millivolts |
| ss_done | input | 1 | Soft-start has completed |
| power_good | output | 1 | Output inside window, no fault |
| hs_force_off | output | 1 | Hold high-side switch off |
| ls_force_on | output | 1 | Crowbar: hold low-side switch on |
| ls_force_off | output | 1 | Hold low-side switch off |
| uv_fault | output | 1 | Latched undervoltage |
| ov_fault | output | 1 | Latched overvoltage |

## Verification
The bench builds the block with its default parameters:
- a 12-bit sense code;
- limits at 1000, 600, 890 and 710 mV;
- an 800 mV reference;
- a 20 mV window hysteresis.

With these values the full-scale code 4095 stands in for a floating sense line. Every threshold code and its neighbour one millivolt away can be driven exactly. The hysteresis edges at 870 and 730 fall on round numbers. A single sequence therefore covers several cases:
- the boundaries;
- the crowbar release and re-arm;
- overvoltage overriding an existing undervoltage;
- the masking of undervoltage before soft-start.

// File: rtl/vwin_pkg.sv
package vwin_pkg;

    // Comparator bank slot assignment
    localparam int CMP_N        = 7;
    localparam int IDX_OV_TRIP  = 0;   // sense above overvoltage limit
    localparam int IDX_UV_TRIP  = 1;   // sense below undervoltage limit
    localparam int IDX_HI_TRIP  = 2;   // sense above window top
    localparam int IDX_HI_CLR   = 3;   // sense back under window top minus hysteresis
    localparam int IDX_LO_TRIP  = 4;   // sense below window bottom
    localparam int IDX_LO_CLR   = 5;   // sense back over window bottom plus hysteresis
    localparam int IDX_REL      = 6;   // sense below crowbar release level

    typedef struct packed {
        logic ss_seen;
        logic out_hi;
        logic out_lo;
    } pg_state_t;

    typedef struct packed {
        logic uv;
        logic ov;
        logic crowbar;
    } flt_state_t;

endpackage

// File: rtl/vwin_cmp.sv
module vwin_cmp #(
    parameter int                        W     = 12,
    parameter int                        N     = 7,
    parameter logic [N*W-1:0]            THR   = '0,
    parameter logic [N-1:0]              ABOVE = '0
) (
    input  logic [W-1:0] sense,
    output logic [N-1:0] hit
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        localparam logic [W-1:0] T = THR[i*W +: W];
        if (ABOVE[i]) begin : g_above
            assign hit[i] = (sense > T);
        end else begin : g_below
            assign hit[i] = (sense < T);
        end
    end

endmodule

// File: rtl/vwin_pg_window.sv
module vwin_pg_window
    import vwin_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample_valid,
    input  logic ss_done,
    input  logic hi_trip,
    input  logic hi_clr,
    input  logic lo_trip,
    input  logic lo_clr,
    input  logic fault_any,
    output logic ss_armed,
    output logic power_good
);

    pg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ss_done) begin
            st_d.ss_seen = 1'b1;
        end
        if (sample_valid) begin
            if (hi_trip) begin
                st_d.out_hi = 1'b1;
            end else if (hi_clr) begin
                st_d.out_hi = 1'b0;
            end
            if (lo_trip) begin
                st_d.out_lo = 1'b1;
            end else if (lo_clr) begin
                st_d.out_lo = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ss_seen <= 1'b0;
            st_q.out_hi  <= 1'b0;
            st_q.out_lo  <= 1'b1;   // no sample yet: treat as outside window
        end else begin
            st_q <= st_d;
        end
    end

    assign ss_armed   = st_q.ss_seen | ss_done;
    assign power_good = st_q.ss_seen & ~st_q.out_hi & ~st_q.out_lo & ~fault_any;

endmodule

// File: rtl/vwin_fault_latch.sv
module vwin_fault_latch
    import vwin_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sample_valid,
    input  logic ss_armed,
    input  logic ov_trip,
    input  logic uv_trip,
    input  logic rel_hit,
    output logic uv_fault,
    output logic ov_fault,
    output logic hs_force_off,
    output logic ls_force_on,
    output logic ls_force_off
);

    flt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sample_valid) begin
            if (ov_trip) begin
                st_d.ov      = 1'b1;
                st_d.crowbar = 1'b1;
            end else if (st_q.ov && rel_hit) begin
                st_d.crowbar = 1'b0;
            end
            if (uv_trip && ss_armed) begin
                st_d.uv = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign uv_fault     = st_q.uv;
    assign ov_fault     = st_q.ov;
    assign hs_force_off = st_q.uv | st_q.ov;
    assign ls_force_on  = st_q.crowbar;
    assign ls_force_off = st_q.uv & ~st_q.ov;

endmodule

// File: rtl/vwin_monitor.sv
module vwin_monitor
    import vwin_pkg::*;
#(
    parameter int SENSE_W   = 12,
    parameter int OV_MV     = 1000,
    parameter int UV_MV     = 600,
    parameter int PG_HI_MV  = 890,
    parameter int PG_LO_MV  = 710,
    parameter int VREF_MV   = 800,
    parameter int HYST_MV   = 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sample_valid,
    input  logic [SENSE_W-1:0] sense_mv,
    input  logic               ss_done,
    output logic               power_good,
    output logic               hs_force_off,
    output logic               ls_force_on,
    output logic               ls_force_off,
    output logic               uv_fault,
    output logic               ov_fault
);

    localparam int REL_MV = VREF_MV / 2;

    // Slot order follows IDX_* in the package (slot 0 at the LSB)
    localparam logic [CMP_N*SENSE_W-1:0] THR_VEC = {
        SENSE_W'(REL_MV),
        SENSE_W'(PG_LO_MV + HYST_MV - 1),
        SENSE_W'(PG_LO_MV),
        SENSE_W'(PG_HI_MV - HYST_MV + 1),
        SENSE_W'(PG_HI_MV),
        SENSE_W'(UV_MV),
        SENSE_W'(OV_MV)
    };
    localparam logic [CMP_N-1:0] ABOVE_VEC = 7'b0100101;

    logic [CMP_N-1:0] hit;
    logic             ss_armed;

    vwin_cmp #(
        .W     (SENSE_W),
        .N     (CMP_N),
        .THR   (THR_VEC),
        .ABOVE (ABOVE_VEC)
    ) u_cmp (
        .sense (sense_mv),
        .hit   (hit)
    );

    vwin_pg_window u_pg (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .ss_done      (ss_done),
        .hi_trip      (hit[IDX_HI_TRIP]),
        .hi_clr       (hit[IDX_HI_CLR]),
        .lo_trip      (hit[IDX_LO_TRIP]),
        .lo_clr       (hit[IDX_LO_CLR]),
        .fault_any    (hs_force_off),
        .ss_armed     (ss_armed),
        .power_good   (power_good)
    );

    vwin_fault_latch u_flt (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .ss_armed     (ss_armed),
        .ov_trip      (hit[IDX_OV_TRIP]),
        .uv_trip      (hit[IDX_UV_TRIP]),
        .rel_hit      (hit[IDX_REL]),
        .uv_fault     (uv_fault),
        .ov_fault     (ov_fault),
        .hs_force_off (hs_force_off),
        .ls_force_on  (ls_force_on),
        .ls_force_off (ls_force_off)
    );

endmodule

// File: rtl/vwin_monitor_chk.sv
module vwin_monitor_chk #(
    parameter int SENSE_W = 12,
    parameter int OV_MV   = 1000,
    parameter int REL_MV  = 400
) (
    input logic               clk,
    input logic               rst,
    input logic               sample_valid,
    input logic [SENSE_W-1:0] sense_mv,
    input logic               power_good,
    input logic               hs_force_off,
    input logic               ls_force_on,
    input logic               ls_force_off,
    input logic               uv_fault,
    input logic               ov_fault
);

    localparam logic [SENSE_W-1:0] OV_C  = SENSE_W'(OV_MV);
    localparam logic [SENSE_W-1:0] REL_C = SENSE_W'(REL_MV);

    AST_LS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        !(ls_force_on && ls_force_off)); // R11

    AST_OV_TRIP: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && sense_mv > OV_C) |=> (ov_fault && ls_force_on && hs_force_off)); // R6

    AST_OV_STICKY: assert property (@(posedge clk) disable iff (rst)
        ov_fault |=> ov_fault); // R6

    AST_UV_STICKY: assert property (@(posedge clk) disable iff (rst)
        uv_fault |=> uv_fault); // R4

    AST_CROWBAR_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (ov_fault && sample_valid && sense_mv < REL_C) |=> !ls_force_on); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !sample_valid |=> $stable({uv_fault, ov_fault, ls_force_on})); // R10

    AST_PG_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
        power_good |-> !hs_force_off); // R2

endmodule

bind vwin_monitor vwin_monitor_chk #(
    .SENSE_W (SENSE_W),
    .OV_MV   (OV_MV),
    .REL_MV  (VREF_MV / 2)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .sample_valid (sample_valid),
    .sense_mv     (sense_mv),
    .power_good   (power_good),
    .hs_force_off (hs_force_off),
    .ls_force_on  (ls_force_on),
    .ls_force_off (ls_force_off),
    .uv_fault     (uv_fault),
    .ov_fault     (ov_fault)
);

// File: tb/sim_vwin_monitor.sv
module sim_vwin_monitor;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sample_valid = 1'b0;
    logic [11:0] sense_mv = '0;
    logic        ss_done = 1'b0;
    logic        power_good, hs_force_off, ls_force_on, ls_force_off, uv_fault, ov_fault;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    typedef struct {
        logic [5:0] exp;
        string      tag;
    } item_t;
    item_t sb_q[$];

    always #4 clk = ~clk;   // 125 MHz

    vwin_monitor u0 (
        .clk          (clk),
        .rst          (rst),
        .sample_valid (sample_valid),
        .sense_mv     (sense_mv),
        .ss_done      (ss_done),
        .power_good   (power_good),
        .hs_force_off (hs_force_off),
        .ls_force_on  (ls_force_on),
        .ls_force_off (ls_force_off),
        .uv_fault     (uv_fault),
        .ov_fault     (ov_fault)
    );

    // Expected vector bit order: {power_good, hs_force_off, ls_force_on, ls_force_off, uv_fault, ov_fault}
    task automatic step(input logic r, input logic v, input int s, input logic ss,
                        input logic [5:0] e, input string tag);
        item_t it;
        @(negedge clk);
        rst          = r;
        sample_valid = v;
        sense_mv     = 12'(s);
        ss_done      = ss;
        it.exp = e;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // Monitor: compares one registered result per clock, away from the edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                item_t it;
                logic [5:0] act;
                it  = sb_q.pop_front();
                act = {power_good, hs_force_off, ls_force_on, ls_force_off, uv_fault, ov_fault};
                checks++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s: actual %b expected %b", it.tag, act, it.exp);
                end
            end
        end
    end

    // Watchdog
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 5000) begin
                fails++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
                $display("[TB] %0d tests run, %0d failed", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        step(1, 0, 0,    0, 6'b000000, "R1 reset state");
        step(0, 1, 500,  0, 6'b000000, "R5 low sample before soft-start");
        step(0, 1, 800,  0, 6'b000000, "R2 in window but no soft-start");
        step(0, 0, 800,  1, 6'b100000, "R2 soft-start seen");
        step(0, 1, 890,  1, 6'b100000, "R12 window top exact");
        step(0, 1, 710,  1, 6'b100000, "R12 window bottom exact");
        step(0, 1, 891,  1, 6'b000000, "R3 above window");
        step(0, 1, 880,  1, 6'b000000, "R3 inside hysteresis high");
        step(0, 1, 870,  1, 6'b100000, "R3 regain high side");
        step(0, 1, 709,  1, 6'b000000, "R3 below window");
        step(0, 1, 720,  1, 6'b000000, "R3 inside hysteresis low");
        step(0, 1, 730,  1, 6'b100000, "R3 regain low side");
        step(0, 0, 300,  1, 6'b100000, "R10 invalid low sample ignored");
        step(0, 1, 600,  1, 6'b000000, "R12 uv limit exact");
        step(0, 1, 599,  1, 6'b010110, "R4 uv latch");
        step(0, 1, 800,  1, 6'b010110, "R4 uv stays latched");
        step(0, 0, 1200, 1, 6'b010110, "R10 invalid high sample ignored");
        step(0, 1, 1000, 1, 6'b010110, "R12 ov limit exact");
        step(0, 1, 1001, 1, 6'b011011, "R11 ov overrides uv");
        step(0, 1, 500,  1, 6'b011011, "R7 crowbar holds mid range");
        step(0, 1, 399,  1, 6'b010011, "R11 release keeps ls_force_off low");
        step(0, 1, 1100, 1, 6'b011011, "R8 crowbar re-arm");
        step(1, 0, 0,    0, 6'b000000, "R1 reset clears latches");
        step(0, 1, 4095, 0, 6'b011001, "R9 full scale is overvoltage");
        step(0, 1, 400,  0, 6'b011001, "R7 release level exact holds");
        step(0, 0, 100,  0, 6'b011001, "R10 invalid sample no release");
        step(0, 1, 399,  0, 6'b010001, "R7 crowbar release");
        step(0, 1, 800,  1, 6'b010001, "R6 ov sticky, no power good");
        step(0, 1, 1500, 1, 6'b011001, "R8 re-arm after release");
        step(1, 0, 0,    0, 6'b000000, "R1 final reset");
        step(0, 1, 1001, 0, 6'b011001, "R6 ov without soft-start");
        wait (sb_q.size() == 0);
        @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule